// File: doc/BRIEF.md
# Held-Grant Switch Allocator

This block performs switch allocation for a wormhole router in which only the first flit of a packet takes part in arbitration. Each output port owns a grant register. When a head flit wins the round-robin arbiter of its output, the winning input is written into that register. The register then steers the crossbar for the rest of the packet. Body and tail flits never arbitrate: they inherit the stored grant and leave their input queue in every cycle in which their output has a free buffer slot. A packet therefore streams at one flit per cycle once its head has been granted. The tail flit's transfer empties the register, and the output is then open to new heads.

Each output keeps its own credit counter. A flit is written into the output register only when it is valid, it is addressed to that output, it belongs to the owning input, and the output has at least one credit. The output register holds the selected data and a valid bit that is driven only by such legal flits. The input queues sit outside the block. They present their front flit with head and tail marks, and they pop it when the block raises the dequeue strobe.

Top module: `hg_switch_alloc`

## Requirements
- R1: After reset, every output valid bit is 0, every dequeue strobe is 0, every crossbar select is 0, and every credit counter holds CRED_MAX.
- R2: A head flit (in_head=1) requests its output (in_dest, binary index) only while that output has credit. While the output's grant register is empty, the arbiter stores the winner as a one-hot input vector on xbar_sel. The head is dequeued in the cycle after it wins, never in the cycle it wins.
- R3: Once the grant is held, body and tail flits of the owning input are dequeued in every cycle in which the output has credit. Consecutive flits of a packet leave in consecutive cycles.
- R4: The dequeue of a flit with in_tail=1 clears the output's grant register at the next edge. A waiting head for that output can win in the following cycle.
- R5: A single-flit packet (in_head=1 and in_tail=1) sets the grant when it wins and clears it when it leaves one cycle later. Back-to-back single-flit packets from one input therefore leave every second cycle.
- R6: No arbitration takes place for an output while its grant register is non-empty. The grant register is always zero or one-hot.
- R7: Arbitration is round-robin per output. After input k wins, the search for the next winner starts at input k+1, modulo NPORT.
- R8: The credit counter of an output decrements for each flit written to it and increments for each cycle in which credit_ret is high for it. A return and a write in the same cycle leave the counter unchanged. At zero credits no flit is dequeued for that output, head or not.
- R9: out_valid for an output goes high exactly one cycle after a flit is dequeued toward it, with out_data equal to that flit's data.
- R10: out_valid stays low whenever no legal flit was transferred in the previous cycle. This includes cycles in which the owning input shows a valid flit but the output has no credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NPORT | Front flit of each input queue is valid |
| in_head | input | NPORT | Front flit opens a packet |
| in_tail | input | NPORT | Front flit closes a packet |
| in_dest | input | NPORT*PW | Destination output index of each front flit |
| in_data | input | NPORT*DW | Payload of each front flit |
| credit_ret | input | NPORT | One credit returned to each output this cycle |
| in_deq | output | NPORT | Pop strobe for each input queue |
| out_valid | output | NPORT | Output register holds a legal flit |
| out_data | output | NPORT*DW | Output register payload |
| xbar_sel | output | NPORT*NPORT | Stored grant per output, one-hot over inputs |

## Verification
Two functions act on the same credit counter in one cycle: the consumption of a credit by a streaming flit and the return of a credit from downstream. The bench provokes this with a six-flit packet, longer than the credit pool, while returning one credit per observed output flit. It judges the result by requiring all six flits to leave in consecutive cycles with no stall. A second collision is the tail's release of a grant and a head from another input already waiting on the same output. Here the bench requires the waiting head to leave exactly two cycles after the tail.

// File: rtl/hg_pkg.sv
package hg_pkg;

  typedef enum logic [1:0] {
    FK_BODY = 2'b00,
    FK_HEAD = 2'b01,
    FK_TAIL = 2'b10,
    FK_SOLO = 2'b11
  } flit_kind_e;

  function automatic flit_kind_e kind_of(input logic head, input logic tail);
    return flit_kind_e'({tail, head});
  endfunction

  function automatic logic opens_packet(input flit_kind_e k);
    return (k == FK_HEAD) || (k == FK_SOLO);
  endfunction

  function automatic logic closes_packet(input flit_kind_e k);
    return (k == FK_TAIL) || (k == FK_SOLO);
  endfunction

endpackage

// File: rtl/hg_rr_arb.sv
module hg_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         update,
  output logic [N-1:0] grant
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q;

  function automatic logic [N-1:0] rr_pick(input logic [N-1:0] r, input logic [PW-1:0] p);
    logic [N-1:0] g;
    logic found;
    g = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(p) + k) % N;
      if (!found && r[idx]) begin
        g[idx] = 1'b1;
        found  = 1'b1;
      end
    end
    return g;
  endfunction

  function automatic logic [PW-1:0] after_winner(input logic [N-1:0] g, input logic [PW-1:0] p);
    logic [PW-1:0] n;
    n = p;
    for (int k = 0; k < N; k++) begin
      if (g[k]) n = PW'((k + 1) % N);
    end
    return n;
  endfunction

  assign grant = rr_pick(req, ptr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ptr_q <= '0;
    else if (update && |req)   ptr_q <= after_winner(grant, ptr_q);
  end
endmodule

// File: rtl/hg_credit.sv
module hg_credit #(
  parameter int MAXC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic give,
  output logic ok
);
  localparam int CW = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] credit_next(input logic [CW-1:0] c, input logic t, input logic g);
    logic [CW-1:0] r;
    r = c;
    if (t) r = r - 1'b1;
    if (g) r = r + 1'b1;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CW'(MAXC);
    else        cnt_q <= credit_next(cnt_q, take, give);
  end

  assign ok = (cnt_q != '0);
endmodule

// File: rtl/hg_out_port.sv
module hg_out_port #(
  parameter int N  = 4,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arb_go,
  input  logic [N-1:0]    win,
  input  logic            tail_leave,
  input  logic            legal,
  input  logic [N*DW-1:0] data_flat,
  output logic [N-1:0]    grant_q,
  output logic            out_valid,
  output logic [DW-1:0]   out_data
);
  function automatic logic [DW-1:0] steer(input logic [N-1:0] g, input logic [N*DW-1:0] d);
    logic [DW-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      acc = acc | (d[i*DW +: DW] & {DW{g[i]}});
    end
    return acc;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (tail_leave)  grant_q <= '0;
      else if (arb_go) grant_q <= win;
      out_valid <= legal;
      if (legal) out_data <= steer(grant_q, data_flat);
    end
  end
endmodule

// File: rtl/hg_switch_alloc.sv
module hg_switch_alloc #(
  parameter int NPORT    = 4,
  parameter int DW       = 8,
  parameter int CRED_MAX = 4,
  parameter int PW       = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORT-1:0]       in_valid,
  input  logic [NPORT-1:0]       in_head,
  input  logic [NPORT-1:0]       in_tail,
  input  logic [NPORT*PW-1:0]    in_dest,
  input  logic [NPORT*DW-1:0]    in_data,
  input  logic [NPORT-1:0]       credit_ret,
  output logic [NPORT-1:0]       in_deq,
  output logic [NPORT-1:0]       out_valid,
  output logic [NPORT*DW-1:0]    out_data,
  output logic [NPORT*NPORT-1:0] xbar_sel
);
  import hg_pkg::*;

  // Named internal events, observed by the bound checker
  logic [NPORT-1:0]       arb_go;
  logic [NPORT-1:0]       legal;
  logic [NPORT-1:0]       tail_leave;
  logic [NPORT-1:0]       cred_ok;
  logic [NPORT*NPORT-1:0] win_flat;

  logic [NPORT-1:0] opens, closes;
  logic [NPORT-1:0] match [NPORT];

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      opens[i]  = opens_packet(kind_of(in_head[i], in_tail[i]));
      closes[i] = closes_packet(kind_of(in_head[i], in_tail[i]));
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    logic [NPORT-1:0] to_here, hreq, arb_pick, own;
    logic [NPORT-1:0] grant_q;

    always_comb begin
      for (int i = 0; i < NPORT; i++) begin
        to_here[i] = in_valid[i] && (in_dest[i*PW +: PW] == PW'(o));
      end
    end

    // Head requests are qualified by this output's credit
    assign hreq          = to_here & opens & {NPORT{cred_ok[o]}};
    assign arb_go[o]     = (|hreq) && (grant_q == '0);
    assign own           = to_here & grant_q & {NPORT{cred_ok[o]}};
    assign match[o]      = own;
    assign legal[o]      = |own;
    assign tail_leave[o] = |(own & closes);
    assign win_flat[o*NPORT +: NPORT] = arb_pick & {NPORT{arb_go[o]}};
    assign xbar_sel[o*NPORT +: NPORT] = grant_q;

    hg_rr_arb #(.N(NPORT)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (hreq),
      .update (arb_go[o]),
      .grant  (arb_pick)
    );

    hg_credit #(.MAXC(CRED_MAX)) u_cred (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (legal[o]),
      .give  (credit_ret[o]),
      .ok    (cred_ok[o])
    );

    hg_out_port #(.N(NPORT), .DW(DW)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .arb_go     (arb_go[o]),
      .win        (win_flat[o*NPORT +: NPORT]),
      .tail_leave (tail_leave[o]),
      .legal      (legal[o]),
      .data_flat  (in_data),
      .grant_q    (grant_q),
      .out_valid  (out_valid[o]),
      .out_data   (out_data[o*DW +: DW])
    );
  end

  always_comb begin
    in_deq = '0;
    for (int o = 0; o < NPORT; o++) begin
      in_deq = in_deq | match[o];
    end
  end
endmodule

// File: rtl/hg_checker.sv
module hg_checker #(
  parameter int NPORT = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NPORT-1:0]       arb_go,
  input logic [NPORT-1:0]       legal,
  input logic [NPORT-1:0]       tail_leave,
  input logic [NPORT-1:0]       cred_ok,
  input logic [NPORT*NPORT-1:0] win_flat,
  input logic [NPORT*NPORT-1:0] xbar_sel,
  input logic [NPORT-1:0]       in_deq,
  input logic [NPORT-1:0]       out_valid
);
  logic [NPORT-1:0] owned;

  always_comb begin
    owned = '0;
    for (int o = 0; o < NPORT; o++) begin
      owned = owned | xbar_sel[o*NPORT +: NPORT];
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_chk
    // R6
    p_grant_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(xbar_sel[o*NPORT +: NPORT]));
    // R6
    p_no_arb_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      arb_go[o] |-> (xbar_sel[o*NPORT +: NPORT] == '0));
    // R2
    p_win_stored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      arb_go[o] |=> (xbar_sel[o*NPORT +: NPORT] == $past(win_flat[o*NPORT +: NPORT])));
    // R4
    p_tail_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tail_leave[o] |=> (xbar_sel[o*NPORT +: NPORT] == '0));
    // R6
    p_grant_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tail_leave[o] && !arb_go[o]) |=> $stable(xbar_sel[o*NPORT +: NPORT]));
    // R8
    p_no_overdraw_r8: assert property (@(posedge clk) disable iff (!rst_n)
      legal[o] |-> cred_ok[o]);
    // R9
    p_out_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      legal[o] |=> out_valid[o]);
    // R10
    p_out_legal_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !legal[o] |=> !out_valid[o]);
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    // R3
    p_deq_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_deq[i] |-> owned[i]);
  end
endmodule

bind hg_switch_alloc hg_checker #(.NPORT(NPORT)) u_hg_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .arb_go     (arb_go),
  .legal      (legal),
  .tail_leave (tail_leave),
  .cred_ok    (cred_ok),
  .win_flat   (win_flat),
  .xbar_sel   (xbar_sel),
  .in_deq     (in_deq),
  .out_valid  (out_valid)
);

// File: tb/hg_switch_alloc_bench.sv
`timescale 1ns/100ps
module hg_switch_alloc_bench;
  localparam int NP = 4;
  localparam int DW = 8;
  localparam int PW = 2;
  localparam int CM = 4;
  localparam int QD = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]    in_valid = '0, in_head = '0, in_tail = '0, credit_ret = '0;
  logic [NP*PW-1:0] in_dest = '0;
  logic [NP*DW-1:0] in_data = '0;
  logic [NP-1:0]    in_deq, out_valid;
  logic [NP*DW-1:0] out_data;
  logic [NP*NP-1:0] xbar_sel;

  hg_switch_alloc #(.NPORT(NP), .DW(DW), .CRED_MAX(CM)) u_hg_switch_alloc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_head(in_head),
    .in_tail(in_tail), .in_dest(in_dest), .in_data(in_data),
    .credit_ret(credit_ret), .in_deq(in_deq), .out_valid(out_valid),
    .out_data(out_data), .xbar_sel(xbar_sel)
  );

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  // Bench-side input queues
  logic [DW-1:0] qd   [NP][QD];
  logic [PW-1:0] qdst [NP][QD];
  bit            qh   [NP][QD];
  bit            qt   [NP][QD];
  int qlen [NP];
  int qptr [NP];
  int dcnt [NP];
  int dcyc [NP][QD];
  int ov_cnt [NP];
  logic [NP-1:0] pend_v = '0;
  logic [DW-1:0] pend_d [NP];
  logic [NP-1:0] last_ov = '0;
  logic [NP-1:0] man_ret = '0;
  bit auto_ret = 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic drive();
    for (int i = 0; i < NP; i++) begin
      bit v;
      v = qptr[i] < qlen[i];
      in_valid[i] = v;
      in_head[i]  = v ? qh[i][qptr[i]] : 1'b0;
      in_tail[i]  = v ? qt[i][qptr[i]] : 1'b0;
      in_dest[i*PW +: PW] = v ? qdst[i][qptr[i]] : '0;
      in_data[i*DW +: DW] = v ? qd[i][qptr[i]] : '0;
    end
  endtask

  task automatic load(input int i, input int dest, input int n, input int tag);
    for (int k = 0; k < n; k++) begin
      qd[i][qlen[i]]   = DW'((tag << 4) | (k & 15));
      qdst[i][qlen[i]] = PW'(dest);
      qh[i][qlen[i]]   = (k == 0);
      qt[i][qlen[i]]   = (k == n - 1);
      qlen[i]++;
    end
  endtask

  // One cycle: sample at the falling edge, update inputs just after the rising edge
  task automatic step();
    logic [NP-1:0] deq_seen;
    @(negedge clk);
    cyc++;
    for (int o = 0; o < NP; o++) begin
      chk(out_valid[o] == pend_v[o], pend_v[o] ? "R9 out_valid after dequeue" : "R10 no valid without legal flit",
          int'(out_valid[o]), int'(pend_v[o]));
      if (out_valid[o]) begin
        ov_cnt[o]++;
        if (pend_v[o]) chk(out_data[o*DW +: DW] == pend_d[o], "R9 out_data", int'(out_data[o*DW +: DW]), int'(pend_d[o]));
      end
    end
    last_ov = out_valid;
    pend_v = '0;
    for (int i = 0; i < NP; i++) begin
      if (in_deq[i]) begin
        chk(qptr[i] < qlen[i], "R3 dequeue of present flit", qptr[i], qlen[i]);
        if (qptr[i] < qlen[i]) begin
          pend_v[qdst[i][qptr[i]]] = 1'b1;
          pend_d[qdst[i][qptr[i]]] = qd[i][qptr[i]];
        end
        dcyc[i][dcnt[i]] = cyc;
        dcnt[i]++;
      end
    end
    deq_seen = in_deq;
    @(posedge clk);
    #1;
    for (int i = 0; i < NP; i++) if (deq_seen[i]) qptr[i]++;
    credit_ret = auto_ret ? last_ov : man_ret;
    drive();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == '0, "R1 out_valid reset", int'(out_valid), 0);
    chk(in_deq == '0, "R1 in_deq reset", int'(in_deq), 0);
    chk(xbar_sel == '0, "R1 xbar_sel reset", int'(xbar_sel), 0);
  endtask

  // Long packet streams while credits are consumed and returned in the same cycles
  task automatic t_stream();
    int s, b;
    s = cyc + 1; b = dcnt[0];
    load(0, 1, 6, 1); drive();
    repeat (12) step();
    chk(dcnt[0] - b == 6, "R3 six flits left", dcnt[0] - b, 6);
    chk(dcyc[0][b] == s + 1, "R2 head leaves cycle after win", dcyc[0][b] - s, 1);
    for (int k = 1; k < 6; k++)
      chk(dcyc[0][b + k] == dcyc[0][b + k - 1] + 1, "R3 back-to-back with R8 return", dcyc[0][b + k] - dcyc[0][b + k - 1], 1);
    chk(xbar_sel[1*NP +: NP] == '0, "R4 grant cleared after tail", int'(xbar_sel[1*NP +: NP]), 0);
  endtask

  // Two heads contend; the second waits for the first packet's tail
  task automatic t_contend();
    int s, b0, b2;
    s = cyc + 1; b0 = dcnt[0]; b2 = dcnt[2];
    load(0, 3, 2, 2); load(2, 3, 2, 3); drive();
    step();
    chk(xbar_sel[3*NP +: NP] == 4'b0001, "R2 winner stored", int'(xbar_sel[3*NP +: NP]), 1);
    repeat (10) step();
    chk(dcyc[0][b0] == s + 1, "R2 input0 head", dcyc[0][b0] - s, 1);
    chk(dcyc[0][b0 + 1] == s + 2, "R3 input0 tail", dcyc[0][b0 + 1] - s, 2);
    chk(dcyc[2][b2] == s + 4, "R6 R4 input2 head after release", dcyc[2][b2] - s, 4);
    chk(dcyc[2][b2 + 1] == s + 5, "R3 input2 tail", dcyc[2][b2 + 1] - s, 5);
  endtask

  // Round-robin: after input 2 won output 3, input 3 has priority over input 2
  task automatic t_rr();
    int s, b2, b3;
    s = cyc + 1; b2 = dcnt[2]; b3 = dcnt[3];
    load(2, 3, 1, 4); load(3, 3, 1, 5); drive();
    repeat (8) step();
    chk(dcyc[3][b3] == s + 1, "R7 input3 first", dcyc[3][b3] - s, 1);
    chk(dcyc[2][b2] == s + 3, "R7 input2 second", dcyc[2][b2] - s, 3);
  endtask

  // Single-flit packets: set and clear per transfer, one every second cycle
  task automatic t_solo();
    int s, b;
    s = cyc + 1; b = dcnt[1];
    load(1, 2, 1, 6); load(1, 2, 1, 7); load(1, 2, 1, 8); drive();
    repeat (10) step();
    chk(dcnt[1] - b == 3, "R5 three solo flits", dcnt[1] - b, 3);
    for (int k = 0; k < 3; k++)
      chk(dcyc[1][b + k] == s + 1 + 2 * k, "R5 solo spacing", dcyc[1][b + k] - s, 1 + 2 * k);
    chk(xbar_sel[2*NP +: NP] == '0, "R5 grant free", int'(xbar_sel[2*NP +: NP]), 0);
  endtask

  // Credit exhaustion stalls the stream; returns resume it
  task automatic t_credit();
    int b, ov0;
    auto_ret = 0; man_ret = '0;
    b = dcnt[0]; ov0 = ov_cnt[0];
    load(0, 0, 6, 9); drive();
    repeat (10) step();
    chk(dcnt[0] - b == CM, "R8 stall at zero credit", dcnt[0] - b, CM);
    chk(ov_cnt[0] - ov0 == CM, "R10 no valid while starved", ov_cnt[0] - ov0, CM);
    chk(xbar_sel[0 +: NP] == 4'b0001, "R6 grant held while stalled", int'(xbar_sel[0 +: NP]), 1);
    man_ret = 4'b0001;
    step(); step();
    man_ret = '0;
    repeat (6) step();
    chk(dcnt[0] - b == 6, "R8 resume after returns", dcnt[0] - b, 6);
    chk(ov_cnt[0] - ov0 == 6, "R9 all flits written", ov_cnt[0] - ov0, 6);
    chk(xbar_sel[0 +: NP] == '0, "R4 grant cleared by tail", int'(xbar_sel[0 +: NP]), 0);
    auto_ret = 1;
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin
      qlen[i] = 0; qptr[i] = 0; dcnt[i] = 0; ov_cnt[i] = 0; pend_d[i] = '0;
    end
    repeat (3) @(posedge clk);
    t_reset();
    @(posedge clk); #1;
    rst_n = 1'b1;
    drive();
    t_stream();
    t_contend();
    t_rr();
    t_solo();
    t_credit();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule